// File: doc/BRIEF.md
# Instruction-End Commit/Abort and Error-Halt Controller

This block decides how every instruction of a small processor core finishes. When the core signals that an instruction is complete, the controller emits a single global commit enable, and all datapath units then make their pending updates architectural: register files, flags, special registers, data-memory stores, the loop stack and the next program counter. If any unit raises an error strobe during that instruction, the controller emits a global abort enable instead. Every pending update is then thrown away, a clear pulse zeroes the stall cycles still owed to the faulting instruction, and the core halts.

The controller also holds the externally visible run status: a busy flag, a sticky done interrupt bit and an error-code register. A start command sets busy, and the core fetches and executes only while busy is set. A halt, whether from a normal environment call or from an error, clears busy and sets done in one step. An error halt also writes the error code in that same step. A normal halt leaves the stored code as it was.

Top module: `insn_end_ctrl`

## Requirements
- R1: After synchronous reset, busy_o, done_intr_o and err_code_o are all 0, and commit_o, abort_o and stall_clr_o are 0.
- R2: A start_i pulse while the core is idle sets busy_o from the next cycle on. A start_i while busy has no effect.
- R3: While busy, with no qualifying error, commit_req_i gives commit_o = 1 in the same cycle with abort_o = 0.
- R4: While busy, any qualifying error gives abort_o = 1 and stall_clr_o = 1 in the same cycle, and commit_o = 0 even when commit_req_i is high. Commit and abort are never high together.
- R5: In the cycle after an error abort, busy_o is 0, done_intr_o is 1 and err_code_o holds the error's code. The codes are 1 for a bad data address and 2 for a call-stack error.
- R6: When several units flag qualifying errors in the same cycle, err_code_o takes the numerically lowest nonzero code.
- R7: halt_req_i (environment call) while busy, with no error, clears busy_o and sets done_intr_o from the next cycle on. err_code_o keeps its previous value. A commit_req_i in the same cycle is still granted.
- R8: While idle, commit_req_i, error strobes and halt_req_i are ignored: no pulses, and no change to busy_o, done_intr_o or err_code_o.
- R9: An error strobe whose code is 0 (no error) does not qualify. It neither aborts nor halts.
- R10: An error and halt_req_i in the same cycle are treated as an error halt: abort is given and the error code is written.
- R11: done_intr_o and err_code_o hold their values across a later start. Only reset returns them to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start command |
| commit_req_i | input | 1 | Current instruction has finished and asks to commit |
| halt_req_i | input | 1 | Normal halt (environment call) strobe |
| unit_err_i | input | NUM_UNITS | Per-unit error strobe |
| unit_code_i | input | NUM_UNITS*CODE_W | Per-unit error code, unit k in bits [k*CODE_W +: CODE_W] |
| commit_o | output | 1 | Global commit enable pulse |
| abort_o | output | 1 | Global abort (discard pending updates) pulse |
| stall_clr_o | output | 1 | Clear remaining stall cycles |
| busy_o | output | 1 | Status: core running |
| done_intr_o | output | 1 | Interrupt state: done |
| err_code_o | output | CODE_W | Error-code register |

## Verification
Three situations are hard to reach from the ports. In the first, two units flag different codes in the same cycle while a commit request is also pending. In the second, an error and an environment call arrive together. In the third, a strobe is raised with code 0. The stimulus reaches each of them by restarting the core after every halt, so that each collision happens with busy set. A reference model in the bench tracks busy, done and the stored code across these restarts. This shows that the stored code survives a normal halt and a restart, and that the idle-state strobes leave it untouched.

// File: rtl/iec_pkg.sv
package iec_pkg;

    localparam int unsigned ERR_W = 2;

    typedef enum logic [ERR_W-1:0] {
        ERR_NONE       = 2'd0,
        ERR_DATA_ADDR  = 2'd1,
        ERR_CALL_STACK = 2'd2
    } err_code_e;

    typedef struct packed {
        logic commit;
        logic abort;
        logic stall_clr;
    } end_ctl_t;

    typedef struct packed {
        logic halt;
        logic write_code;
    } halt_ctl_t;

endpackage

// File: rtl/iec_err_arb.sv
module iec_err_arb #(
    parameter int unsigned NUM_UNITS = 4,
    parameter int unsigned CODE_W    = 2
) (
    input  logic [NUM_UNITS-1:0]        valid_i,
    input  logic [NUM_UNITS*CODE_W-1:0] codes_i,
    output logic                        any_o,
    output logic [CODE_W-1:0]           code_o
);
    logic [NUM_UNITS-1:0] qual;
    logic [CODE_W-1:0]    code_arr [NUM_UNITS];

    for (genvar g = 0; g < NUM_UNITS; g++) begin : g_qual
        assign code_arr[g] = codes_i[g*CODE_W +: CODE_W];
        assign qual[g]     = valid_i[g] && (code_arr[g] != '0);
    end

    always_comb begin
        code_o = '0;
        for (int i = 0; i < NUM_UNITS; i++) begin
            if (qual[i] && ((code_o == '0) || (code_arr[i] < code_o))) begin
                code_o = code_arr[i];
            end
        end
    end

    assign any_o = |qual;
endmodule

// File: rtl/iec_run_state.sv
module iec_run_state (
    input  logic clk_i,
    input  logic rst_i,
    input  logic start_i,
    input  logic halt_i,
    output logic busy_o
);
    logic busy_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            busy_q <= 1'b0;
        end else if (busy_q && halt_i) begin
            busy_q <= 1'b0;
        end else if (!busy_q && start_i) begin
            busy_q <= 1'b1;
        end
    end

    assign busy_o = busy_q;
endmodule

// File: rtl/iec_status_regs.sv
module iec_status_regs
    import iec_pkg::*;
#(
    parameter int unsigned CODE_W = 2
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  halt_ctl_t         ctl_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              done_o,
    output logic [CODE_W-1:0] code_o
);
    logic              done_q;
    logic [CODE_W-1:0] code_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            done_q <= 1'b0;
            code_q <= '0;
        end else if (ctl_i.halt) begin
            done_q <= 1'b1;
            if (ctl_i.write_code) begin
                code_q <= code_i;
            end
        end
    end

    assign done_o = done_q;
    assign code_o = code_q;
endmodule

// File: rtl/insn_end_ctrl.sv
module insn_end_ctrl
    import iec_pkg::*;
#(
    parameter int unsigned NUM_UNITS = 4,
    parameter int unsigned CODE_W    = iec_pkg::ERR_W
) (
    input  logic                        clk_i,
    input  logic                        rst_i,
    input  logic                        start_i,
    input  logic                        commit_req_i,
    input  logic                        halt_req_i,
    input  logic [NUM_UNITS-1:0]        unit_err_i,
    input  logic [NUM_UNITS*CODE_W-1:0] unit_code_i,
    output logic                        commit_o,
    output logic                        abort_o,
    output logic                        stall_clr_o,
    output logic                        busy_o,
    output logic                        done_intr_o,
    output logic [CODE_W-1:0]           err_code_o
);
    logic              any_err;
    logic [CODE_W-1:0] sel_code;
    logic              busy;
    logic              err_hit;
    end_ctl_t          ctl;
    halt_ctl_t         hctl;

    iec_err_arb #(.NUM_UNITS(NUM_UNITS), .CODE_W(CODE_W)) u_arb (
        .valid_i (unit_err_i),
        .codes_i (unit_code_i),
        .any_o   (any_err),
        .code_o  (sel_code)
    );

    assign err_hit = busy && any_err;

    always_comb begin
        ctl.abort       = err_hit;
        ctl.stall_clr   = err_hit;
        ctl.commit      = busy && commit_req_i && !err_hit;
        hctl.halt       = busy && (err_hit || halt_req_i);
        hctl.write_code = err_hit;
    end

    iec_run_state u_run (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .start_i (start_i),
        .halt_i  (hctl.halt),
        .busy_o  (busy)
    );

    iec_status_regs #(.CODE_W(CODE_W)) u_stat (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .ctl_i  (hctl),
        .code_i (sel_code),
        .done_o (done_intr_o),
        .code_o (err_code_o)
    );

    assign commit_o    = ctl.commit;
    assign abort_o     = ctl.abort;
    assign stall_clr_o = ctl.stall_clr;
    assign busy_o      = busy;
endmodule

// File: rtl/iec_checker.sv
module iec_checker #(
    parameter int unsigned CODE_W = 2
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              start_i,
    input logic              halt_req_i,
    input logic              commit_o,
    input logic              abort_o,
    input logic              stall_clr_o,
    input logic              busy_o,
    input logic              done_intr_o,
    input logic [CODE_W-1:0] err_code_o
);
    AST_COMMIT_ABORT_EXCL: assert property (@(posedge clk_i) disable iff (rst_i)
        !(commit_o && abort_o)); // R4
    AST_ABORT_CLEARS_STALL: assert property (@(posedge clk_i) disable iff (rst_i)
        abort_o |-> stall_clr_o); // R4
    AST_ERR_HALTS: assert property (@(posedge clk_i) disable iff (rst_i)
        abort_o |=> (!busy_o && done_intr_o && err_code_o != '0)); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
        !busy_o |-> (!commit_o && !abort_o)); // R8
    AST_START_BUSY: assert property (@(posedge clk_i) disable iff (rst_i)
        (start_i && !busy_o) |=> busy_o); // R2
    AST_ECALL_KEEPS_CODE: assert property (@(posedge clk_i) disable iff (rst_i)
        (busy_o && halt_req_i && !abort_o) |=> (!busy_o && $stable(err_code_o))); // R7
endmodule

bind insn_end_ctrl iec_checker #(.CODE_W(CODE_W)) u_iec_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .start_i     (start_i),
    .halt_req_i  (halt_req_i),
    .commit_o    (commit_o),
    .abort_o     (abort_o),
    .stall_clr_o (stall_clr_o),
    .busy_o      (busy_o),
    .done_intr_o (done_intr_o),
    .err_code_o  (err_code_o)
);

// File: tb/test_insn_end_ctrl.sv
`timescale 1ns/1ps
module test_insn_end_ctrl;
    localparam int NU = 4;
    localparam int CW = 2;

    typedef struct {
        string      tag;
        logic       commit;
        logic       abort;
        logic       sclr;
        logic       busy;
        logic       done;
        logic [1:0] code;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0, creq = 1'b0, hreq = 1'b0;
    logic [NU-1:0] uerr = '0;
    logic [NU*CW-1:0] ucode = '0;
    logic          commit, abort, sclr, busy, done;
    logic [CW-1:0] code;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    exp_t q[$];

    logic       m_busy = 0, m_done = 0;
    logic [1:0] m_code = 0;

    always #2 clk = ~clk;

    insn_end_ctrl #(.NUM_UNITS(NU), .CODE_W(CW)) i_insn_end_ctrl (
        .clk_i(clk), .rst_i(rst), .start_i(start), .commit_req_i(creq),
        .halt_req_i(hreq), .unit_err_i(uerr), .unit_code_i(ucode),
        .commit_o(commit), .abort_o(abort), .stall_clr_o(sclr),
        .busy_o(busy), .done_intr_o(done), .err_code_o(code)
    );

    task automatic cyc(input string tag, input logic s, input logic c, input logic h,
                       input logic [NU-1:0] ev, input logic [NU*CW-1:0] ec);
        exp_t e;
        logic       any;
        logic [1:0] best;
        @(negedge clk);
        start = s; creq = c; hreq = h; uerr = ev; ucode = ec;
        any = 0; best = 0;
        for (int k = 0; k < NU; k++) begin
            if (ev[k] && ec[k*CW +: CW] != 0) begin
                if (!any || ec[k*CW +: CW] < best) best = ec[k*CW +: CW];
                any = 1;
            end
        end
        any = any && m_busy;
        e.tag = tag; e.busy = m_busy; e.done = m_done; e.code = m_code;
        e.abort = any; e.sclr = any; e.commit = m_busy && c && !any;
        q.push_back(e);
        if (m_busy && (any || h)) begin
            m_busy = 0; m_done = 1;
            if (any) m_code = best;
        end else if (!m_busy && s) begin
            m_busy = 1;
        end
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(negedge clk);
            #1;
            if (q.size() > 0) begin
                e = q.pop_front();
                checks++;
                if ({commit, abort, sclr, busy, done, code} !==
                    {e.commit, e.abort, e.sclr, e.busy, e.done, e.code}) begin
                    errors++;
                    $display("FAIL %s: got c=%b a=%b s=%b busy=%b done=%b code=%0d exp c=%b a=%b s=%b busy=%b done=%b code=%0d",
                             e.tag, commit, abort, sclr, busy, done, code,
                             e.commit, e.abort, e.sclr, e.busy, e.done, e.code);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: got hang exp completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cyc("R1 reset state", 0, 0, 0, '0, '0);
        cyc("R8 idle commit/err ignored", 0, 1, 0, 4'b0010, 8'b0000_1000);
        cyc("R8 idle halt ignored", 0, 0, 1, 4'b0001, 8'b0000_0001);
        cyc("R2 start", 1, 0, 0, '0, '0);
        cyc("R2 busy after start", 1, 0, 0, '0, '0);
        cyc("R3 commit", 0, 1, 0, '0, '0);
        cyc("R4 error beats commit", 0, 1, 0, 4'b0010, 8'b0000_1000);
        cyc("R5 error halt status", 0, 1, 0, '0, '0);
        cyc("R11 restart", 1, 0, 0, '0, '0);
        cyc("R11 status kept", 0, 0, 0, '0, '0);
        cyc("R6 lowest code wins", 0, 1, 0, 4'b1001, 8'b0100_0010);
        cyc("R6 code 1 stored", 1, 0, 0, '0, '0);
        cyc("R9 zero-code strobe", 0, 1, 0, 4'b0100, 8'b0000_0000);
        cyc("R9 still busy", 0, 0, 0, '0, '0);
        cyc("R7 ecall with commit", 0, 1, 1, '0, '0);
        cyc("R7 code unchanged", 0, 0, 0, '0, '0);
        cyc("R10 restart", 1, 0, 0, '0, '0);
        cyc("R10 error with ecall", 0, 0, 1, 4'b0100, 8'b0010_0000);
        cyc("R10 error code written", 0, 0, 0, '0, '0);
        cyc("R8 idle after halt", 0, 1, 1, 4'b0001, 8'b0000_0001);
        cyc("R8 final", 0, 0, 0, '0, '0);
        repeat (3) @(negedge clk);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule